// File: doc/BRIEF.md
# UDP Register Access Command Processor

This block carries out remote register reads and writes that a host sends inside UDP datagrams. It sits after the Ethernet, IP and UDP parsers. It receives the datagram payload as a byte stream, tagged with the UDP destination port of that datagram. Each datagram addressed to port 1001 holds one command of ten bytes: a 16-bit request type, a 32-bit register address and a 32-bit data word, each most significant byte first. The processor decodes the address into a one-hot subsystem select and performs the access on a simple request/acknowledge register bus.

The register bus allows one request at a time. A read is answered with a ten-byte response payload, which the UDP/IP encapsulation logic downstream returns to the host on port 1001. The payload echoes the request type and the address, then carries the read data. A malformed command causes no bus access. It is answered with the same payload layout, and the data slot holds an error code.

Top module: `rac_cmd_proc`

## Requirements
- R1: A datagram whose `rx_port_i` differs from 1001 on any of its bytes is consumed and dropped. It causes no bus request and no response.
- R2: Request type 0x2000 performs a bus read (`bus_we_o`=0) at the command's address.
- R3: Request type 0x2001 performs a bus write (`bus_we_o`=1) of the data field to the command's address. A write that completes produces no response.
- R4: Payload byte 0-1 is the type, byte 2-5 is the address and byte 6-9 is the data, each big-endian. Bytes after the tenth are ignored. A datagram shorter than ten bytes is dropped without effect.
- R5: Address bits [31:28] equal to 0x0 or 0x1 select the processor core region, which is select bit 0.
- R6: When address bits [31:28] equal 0x2, bits [27:24] pick the sub-block. 0x0 selects common (bit 1), 0x1 ethernet (bit 2), 0x2 packet (bit 3), 0x4 to 0xB application (bit 4), 0xC DAC interface (bit 5) and 0xD ADC interface (bit 6). `bus_sel_o` is one-hot while a request is pending and zero otherwise.
- R7: A request type other than 0x2000 or 0x2001 causes no bus access. It is answered with the error code 0xE0000001.
- R8: An address whose region is not 0x0 to 0x2, or whose framework sub-block is 0x3, 0xE or 0xF, causes no bus access. It is answered with the error code 0xE0000002. R7 takes precedence when both apply.
- R9: A response is ten bytes: the type, then the address, then the read data or the error code, each big-endian. `tx_last_o` marks the tenth byte, and `tx_port_o` is 1001.
- R10: Once `bus_req_o` is raised, it stays high with a stable address, select, write flag and write data until `bus_ack_i`. No payload byte is accepted while a request or a response is in progress.
- R11: The bus request, or an error response, appears on the second rising edge after the last payload byte is accepted. A read response appears on the edge after the acknowledgement.
- R12: While `tx_valid_o` is high and `tx_ready_i` is low, the response byte and the last flag hold.
- R13: After reset, `bus_req_o` and `tx_valid_o` are low and `rx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Payload byte valid |
| rx_data_i | input | 8 | Payload byte |
| rx_last_i | input | 1 | Last byte of the datagram |
| rx_port_i | input | 16 | UDP destination port of the datagram |
| rx_ready_o | output | 1 | Payload byte accepted when high with valid |
| tx_valid_o | output | 1 | Response byte valid |
| tx_data_o | output | 8 | Response byte |
| tx_last_o | output | 1 | Last response byte |
| tx_port_o | output | 16 | UDP port for the response |
| tx_ready_i | input | 1 | Downstream takes the response byte |
| bus_req_o | output | 1 | Register bus request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 32 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_sel_o | output | 7 | One-hot subsystem select |
| bus_ack_i | input | 1 | Access complete |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The last payload byte is taken on edge k, and the parsed command is registered then. The request, or the first byte of an error response, is visible after edge k+1. A read response follows on the edge that samples the acknowledgement, and each further byte follows one edge after the previous byte is taken. The bench drives every input on the falling edge and samples outputs there. It counts falling edges from the accepting edge and makes each check at the exact falling edge that these latencies predict, so an extra or a missing register stage is reported. It also holds the acknowledgement and `tx_ready_i` back for some cycles, which shows that requests and response bytes are held while they wait.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam int TYPE_W    = 16;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int CMD_W     = TYPE_W + ADDR_W + DATA_W;
  localparam int CMD_BYTES = CMD_W / 8;

  localparam logic [TYPE_W-1:0] RD_TYPE = 16'h2000;
  localparam logic [TYPE_W-1:0] WR_TYPE = 16'h2001;

  localparam logic [DATA_W-1:0] ERR_BAD_TYPE = 32'hE000_0001;
  localparam logic [DATA_W-1:0] ERR_BAD_ADDR = 32'hE000_0002;

  // select bit positions
  localparam int SEL_CORE = 0;
  localparam int SEL_CMN  = 1;
  localparam int SEL_ETH  = 2;
  localparam int SEL_PKT  = 3;
  localparam int SEL_APP  = 4;
  localparam int SEL_DAC  = 5;
  localparam int SEL_ADC  = 6;
  localparam int SEL_W    = 7;

  typedef struct packed {
    logic [TYPE_W-1:0] rtype;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} fsm_e;
endpackage

// File: rtl/rac_rx_parser.sv
module rac_rx_parser
  import rac_pkg::*;
#(
  parameter int          PORT_W   = 16,
  parameter logic [15:0] UDP_PORT = 16'd1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              last_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              ready_o,
  output logic              cmd_valid_o,
  output cmd_t              cmd_o
);
  localparam int CNT_W = $clog2(CMD_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_BYTES);

  logic [CMD_W-1:0] shift_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             bad_q, bad_nx, fire, room;

  assign ready_o = en_i & ~cmd_valid_o;
  assign fire    = valid_i & ready_o;
  assign room    = cnt_q < FULL;
  assign cnt_nx  = room ? cnt_q + 1'b1 : cnt_q;
  assign bad_nx  = bad_q | (port_i != PORT_W'(UDP_PORT));
  assign cmd_o   = cmd_t'(shift_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q     <= '0;
      cnt_q       <= '0;
      bad_q       <= 1'b0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (fire) begin
        if (room) shift_q <= {shift_q[CMD_W-9:0], data_i};
        if (last_i) begin
          cmd_valid_o <= ~bad_nx & (cnt_nx == FULL);
          cnt_q       <= '0;
          bad_q       <= 1'b0;
        end else begin
          cnt_q <= cnt_nx;
          bad_q <= bad_nx;
        end
      end
    end
  end
endmodule

// File: rtl/rac_addr_decode.sv
module rac_addr_decode
  import rac_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              hit_o
);
  logic [3:0] region, sub;
  assign region = addr_i[ADDR_W-1 -: 4];
  assign sub    = addr_i[ADDR_W-5 -: 4];

  always_comb begin
    sel_o = '0;
    case (region)
      4'h0, 4'h1: sel_o[SEL_CORE] = 1'b1;
      4'h2: begin
        case (sub)
          4'h0: sel_o[SEL_CMN] = 1'b1;
          4'h1: sel_o[SEL_ETH] = 1'b1;
          4'h2: sel_o[SEL_PKT] = 1'b1;
          4'h4, 4'h5, 4'h6, 4'h7,
          4'h8, 4'h9, 4'hA, 4'hB: sel_o[SEL_APP] = 1'b1;
          4'hC: sel_o[SEL_DAC] = 1'b1;
          4'hD: sel_o[SEL_ADC] = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
    hit_o = |sel_o;
  end
endmodule

// File: rtl/rac_tx_builder.sv
module rac_tx_builder
  import rac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  cmd_t       payload_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       last_o
);
  localparam int IDX_W = $clog2(CMD_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_BYTES - 1);

  logic [CMD_W-1:0] buf_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       bytes [CMD_BYTES];

  for (genvar g = 0; g < CMD_BYTES; g++) begin : g_byte
    assign bytes[g] = buf_q[CMD_W-1-8*g -: 8];
  end

  assign data_o = bytes[idx_q];
  assign last_o = valid_o & (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      idx_q   <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      buf_q   <= payload_i;
      idx_q   <= '0;
      valid_o <= 1'b1;
    end else if (valid_o && ready_i) begin
      if (idx_q == LAST_IDX) valid_o <= 1'b0;
      else                   idx_q   <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/rac_cmd_proc.sv
module rac_cmd_proc
  import rac_pkg::*;
#(
  parameter int          PORT_W   = 16,
  parameter logic [15:0] UDP_PORT = 16'd1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic [PORT_W-1:0] rx_port_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic [PORT_W-1:0] tx_port_o,
  input  logic              tx_ready_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [SEL_W-1:0]  bus_sel_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  fsm_e             state_q;
  cmd_t             cmd_w, cmd_q, tx_payload;
  logic             cmd_valid, hit, type_rd, type_wr, type_ok;
  logic             tx_start, tx_done, we_q;
  logic [SEL_W-1:0] sel_w, sel_q;

  rac_rx_parser #(.PORT_W(PORT_W), .UDP_PORT(UDP_PORT)) u_parser (
    .clk_i, .rst_ni,
    .en_i       (state_q == ST_IDLE),
    .valid_i    (rx_valid_i),
    .data_i     (rx_data_i),
    .last_i     (rx_last_i),
    .port_i     (rx_port_i),
    .ready_o    (rx_ready_o),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd_w)
  );

  rac_addr_decode u_dec (.addr_i(cmd_w.addr), .sel_o(sel_w), .hit_o(hit));

  assign type_rd = cmd_w.rtype == RD_TYPE;
  assign type_wr = cmd_w.rtype == WR_TYPE;
  assign type_ok = type_rd | type_wr;

  always_comb begin
    tx_start   = 1'b0;
    tx_payload = cmd_w;
    case (state_q)
      ST_IDLE: if (cmd_valid && !(type_ok && hit)) begin
        tx_start   = 1'b1;
        tx_payload = {cmd_w.rtype, cmd_w.addr, type_ok ? ERR_BAD_ADDR : ERR_BAD_TYPE};
      end
      ST_BUS: if (bus_ack_i && !we_q) begin
        tx_start   = 1'b1;
        tx_payload = {cmd_q.rtype, cmd_q.addr, bus_rdata_i};
      end
      default: ;
    endcase
  end

  rac_tx_builder u_tx (
    .clk_i, .rst_ni,
    .start_i  (tx_start),
    .payload_i(tx_payload),
    .ready_i  (tx_ready_i),
    .valid_o  (tx_valid_o),
    .data_o   (tx_data_o),
    .last_o   (tx_last_o)
  );

  assign tx_done = tx_valid_o & tx_ready_i & tx_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      sel_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          cmd_q   <= cmd_w;
          sel_q   <= sel_w;
          we_q    <= type_wr;
          state_q <= (type_ok && hit) ? ST_BUS : ST_RESP;
        end
        ST_BUS:  if (bus_ack_i) state_q <= we_q ? ST_IDLE : ST_RESP;
        ST_RESP: if (tx_done)   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = state_q == ST_BUS;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = cmd_q.addr;
  assign bus_wdata_o = cmd_q.data;
  assign bus_sel_o   = bus_req_o ? sel_q : '0;
  assign tx_port_o   = PORT_W'(UDP_PORT);
endmodule

// File: rtl/rac_cmd_proc_chk.sv
module rac_cmd_proc_chk
  import rac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_ack_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [SEL_W-1:0]  bus_sel_i,
  input logic              tx_valid_i,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_i,
  input logic              tx_last_i,
  input logic              rx_ready_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_ack_i |=> bus_req_i && $stable(bus_addr_i) && $stable(bus_sel_i)
                                && $stable(bus_we_i) && $stable(bus_wdata_i));
  // R6
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |-> $countones(bus_sel_i) == 1);
  // R6
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |-> bus_sel_i == '0);
  // R8
  region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |-> bus_addr_i[ADDR_W-1 -: 4] < 4'h3);
  // R12
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && !tx_ready_i |=> tx_valid_i && $stable(tx_data_i) && $stable(tx_last_i));
  // R10
  rx_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i || tx_valid_i) |-> !rx_ready_i);
  // R3
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_ack_i && bus_we_i |=> !tx_valid_i);
endmodule

bind rac_cmd_proc rac_cmd_proc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_o),
  .bus_ack_i  (bus_ack_i),
  .bus_we_i   (bus_we_o),
  .bus_addr_i (bus_addr_o),
  .bus_wdata_i(bus_wdata_o),
  .bus_sel_i  (bus_sel_o),
  .tx_valid_i (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_i  (tx_data_o),
  .tx_last_i  (tx_last_o),
  .rx_ready_i (rx_ready_o)
);

// File: tb/rac_cmd_proc_test.sv
`timescale 1ns/1ps
module rac_cmd_proc_test;
  localparam logic [31:0] RD_MASK = 32'h5A5A_A5A5;
  localparam logic [1:0] K_NONE = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_ERR = 2'd3;

  typedef struct packed {
    logic [15:0] port;
    logic [15:0] rtype;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  kind;
    logic [6:0]  sel;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'd1001, 16'h2000, 32'h0000_0010, 32'h0,         K_RD,  7'h01, 32'h0,         8'd5}, // R5 R2
    '{16'd1001, 16'h2001, 32'h1000_0044, 32'h1234_5678, K_WR,  7'h01, 32'h0,         8'd3}, // R3 R5
    '{16'd1001, 16'h2000, 32'h2000_0004, 32'h0,         K_RD,  7'h02, 32'h0,         8'd6}, // R6
    '{16'd1001, 16'h2001, 32'h2100_0008, 32'hAABB_CCDD, K_WR,  7'h04, 32'h0,         8'd6},
    '{16'd1001, 16'h2000, 32'h2200_000C, 32'h0,         K_RD,  7'h08, 32'h0,         8'd6},
    '{16'd1001, 16'h2000, 32'h2400_0000, 32'h0,         K_RD,  7'h10, 32'h0,         8'd6},
    '{16'd1001, 16'h2001, 32'h2B00_0100, 32'h0F0F_0F0F, K_WR,  7'h10, 32'h0,         8'd6},
    '{16'd1001, 16'h2000, 32'h2C00_0000, 32'h0,         K_RD,  7'h20, 32'h0,         8'd6},
    '{16'd1001, 16'h2000, 32'h2D00_0010, 32'h0,         K_RD,  7'h40, 32'h0,         8'd6},
    '{16'd1002, 16'h2000, 32'h0000_0000, 32'h0,         K_NONE,7'h00, 32'h0,         8'd1}, // R1
    '{16'd1001, 16'h2002, 32'h2000_0000, 32'h0,         K_ERR, 7'h00, 32'hE000_0001, 8'd7}, // R7
    '{16'd1001, 16'h2000, 32'h3000_0000, 32'h0,         K_ERR, 7'h00, 32'hE000_0002, 8'd8}, // R8
    '{16'd1001, 16'h2001, 32'h2300_0000, 32'h1,         K_ERR, 7'h00, 32'hE000_0002, 8'd8},
    '{16'd1001, 16'h2000, 32'hF000_0000, 32'h0,         K_ERR, 7'h00, 32'hE000_0002, 8'd8},
    '{16'd1001, 16'h2001, 32'h2E00_0000, 32'h0,         K_ERR, 7'h00, 32'hE000_0002, 8'd8}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0, rx_last_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic [15:0] rx_port_i = '0;
  logic        rx_ready_o, tx_valid_o, tx_last_o;
  logic [7:0]  tx_data_o;
  logic [15:0] tx_port_o;
  logic        tx_ready_i = 1'b1;
  logic        bus_req_o, bus_we_o, bus_ack_i = 1'b0;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i = '0;
  logic [6:0]  bus_sel_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  rac_cmd_proc uut (.*);

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic get_resp(input logic [79:0] w, input int req, input int stall);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      b = w[79-8*i -: 8];
      if (i == stall) begin
        tx_ready_i = 1'b0;
        for (int s = 0; s < 2; s++) begin
          @(negedge clk_i);
          chk(tx_valid_o && tx_data_o == b, 12, "R12 byte held", {24'h0, tx_data_o}, {24'h0, b});
        end
        tx_ready_i = 1'b1;
      end
      chk(tx_valid_o == 1'b1, 9, "R9 response valid", {31'h0, tx_valid_o}, 32'h1);
      chk(tx_data_o == b, req, "R9 response byte", {24'h0, tx_data_o}, {24'h0, b});
      chk(tx_last_o == (i == 9), 9, "R9 last flag", {31'h0, tx_last_o}, {31'h0, i == 9});
      chk(tx_port_o == 16'd1001, 9, "R9 port", {16'h0, tx_port_o}, 32'd1001);
      @(negedge clk_i);
    end
    chk(!tx_valid_o && rx_ready_o, 10, "R10 idle after response", {31'h0, tx_valid_o}, 32'h0);
  endtask

  // called on a falling edge
  task automatic do_cmd(input vec_t v, input int nbytes, input int stall);
    logic [79:0] w;
    w = {v.rtype, v.addr, v.wdata};
    for (int i = 0; i < nbytes; i++) begin
      rx_valid_i = 1'b1;
      rx_data_i  = (i < 10) ? w[79-8*i -: 8] : 8'hEE; // R4 trailing bytes
      rx_last_i  = (i == nbytes - 1);
      rx_port_i  = v.port;
      while (!rx_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0;
    rx_last_i  = 1'b0;
    @(negedge clk_i); // second edge after acceptance (R11)
    case (v.kind)
      K_NONE: begin
        for (int c = 0; c < 6; c++) begin
          chk(!bus_req_o && !tx_valid_o, v.req, "no effect", {30'h0, bus_req_o, tx_valid_o}, 32'h0);
          @(negedge clk_i);
        end
      end
      K_ERR: begin
        chk(!bus_req_o, v.req, "no access on error", {31'h0, bus_req_o}, 32'h0);
        chk(tx_valid_o, 11, "R11 error response timing", {31'h0, tx_valid_o}, 32'h1);
        get_resp({v.rtype, v.addr, v.exp}, v.req, stall);
      end
      default: begin
        chk(bus_req_o, 11, "R11 request timing", {31'h0, bus_req_o}, 32'h1);
        chk(bus_we_o == (v.kind == K_WR), v.req, "write flag", {31'h0, bus_we_o}, {31'h0, v.kind == K_WR});
        chk(bus_addr_o == v.addr, 4, "R4 address", bus_addr_o, v.addr);
        chk(bus_sel_o == v.sel, v.req, "select", {25'h0, bus_sel_o}, {25'h0, v.sel});
        if (v.kind == K_WR) chk(bus_wdata_o == v.wdata, 3, "R3 write data", bus_wdata_o, v.wdata);
        @(negedge clk_i);
        chk(bus_req_o && !rx_ready_o && bus_addr_o == v.addr, 10, "R10 request held",
            {31'h0, bus_req_o}, 32'h1);
        bus_ack_i   = 1'b1;
        bus_rdata_i = v.addr ^ RD_MASK;
        @(negedge clk_i);
        bus_ack_i = 1'b0;
        chk(!bus_req_o, 10, "R10 request drops", {31'h0, bus_req_o}, 32'h0);
        if (v.kind == K_RD) begin
          chk(tx_valid_o, 11, "R11 read response timing", {31'h0, tx_valid_o}, 32'h1);
          get_resp({v.rtype, v.addr, v.addr ^ RD_MASK}, v.req, stall);
        end else begin
          for (int c = 0; c < 3; c++) begin
            chk(!tx_valid_o && rx_ready_o, 3, "R3 no write response", {31'h0, tx_valid_o}, 32'h0);
            @(negedge clk_i);
          end
        end
      end
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk(!bus_req_o && !tx_valid_o && rx_ready_o == 1'b0 || !rst_ni, 13, "R13 in reset",
        {30'h0, bus_req_o, tx_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bus_req_o, 13, "R13 req low", {31'h0, bus_req_o}, 32'h0);
    chk(!tx_valid_o, 13, "R13 tx low", {31'h0, tx_valid_o}, 32'h0);
    chk(rx_ready_o, 13, "R13 rx ready", {31'h0, rx_ready_o}, 32'h1);

    for (int i = 0; i < NV; i++) do_cmd(VECS[i], 10, -1);

    // R4 short datagram dropped
    v = '{16'd1001, 16'h2000, 32'h2000_0000, 32'h0, K_NONE, 7'h0, 32'h0, 8'd4};
    do_cmd(v, 9, -1);
    // R4 trailing bytes ignored
    v = '{16'd1001, 16'h2000, 32'h2C00_0040, 32'h0, K_RD, 7'h20, 32'h0, 8'd4};
    do_cmd(v, 13, -1);
    // R12 backpressure on read and error responses
    v = '{16'd1001, 16'h2000, 32'h2100_0020, 32'h0, K_RD, 7'h04, 32'h0, 8'd12};
    do_cmd(v, 10, 4);
    v = '{16'd1001, 16'h1234, 32'h2100_0020, 32'h0, K_ERR, 7'h0, 32'hE000_0001, 8'd12};
    do_cmd(v, 10, 0);
    // R7 precedence over bad address
    v = '{16'd1001, 16'h0000, 32'hF000_0000, 32'h0, K_ERR, 7'h0, 32'hE000_0001, 8'd7};
    do_cmd(v, 10, -1);
    // R1 then valid command still works
    v = '{16'd999, 16'h2001, 32'h0000_0000, 32'h5, K_NONE, 7'h0, 32'h0, 8'd1};
    do_cmd(v, 10, -1);
    v = '{16'd1001, 16'h2000, 32'h1FFF_FFFC, 32'h0, K_RD, 7'h01, 32'h0, 8'd5};
    do_cmd(v, 10, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule